// File: doc/BRIEF.md
# Wormhole Output Port Controller

This block holds the state and flow control for one output of a wormhole router. Input ports whose waiting head flit targets this output raise a request. A round-robin arbiter picks one requester, and that input then owns the output for its whole packet. The head, body and tail flits all leave through this port without any new arbitration. Inputs that lose keep their head flit buffered and stay blocked.

Flits are gated by a credit counter that mirrors the free buffer space downstream. A flit leaves only while at least one credit is held. Returned credits arrive as single-cycle pulses. Once the tail flit has left, the port sits in a wait state until every credit has come back, so the downstream buffers are empty before another packet is granted.

Top module: `wh_out_port`

## Requirements
- R1: While reset is held, and after it, `state_o` is idle (2'd0), `credit_o` equals `DEPTH`, and `gnt_o`, `pop_o` and `send_o` are zero.
- R2: In idle with any `req_i` bit set, the next cycle is active (2'd1). The owner is the first requesting index found by searching upward from one past the previously granted index, wrapping at `N_IN`. Before the first grant, the previous index is taken to be `N_IN-1`.
- R3: Outside the active state, `send_o` is 0 and `pop_o` is zero whatever the inputs. An input that is not the owner is never popped, so its head flit stays blocked.
- R4: In the active state, `send_o` = `flit_vld_i[owner] && credit_o > 0`, `pop_o` equals `gnt_o` when a flit is sent and zero otherwise, and `sel_o` holds the owner index.
- R5: In the active state, `gnt_o` is one-hot on the owner. It keeps that value, with no re-arbitration, until the tail flit is sent.
- R6: The cycle after a flit marked by `tail_i[owner]` is sent, `state_o` is wait (2'd2).
- R7: In the wait state the port stays in wait while `credit_o` is below `DEPTH`. The cycle after it observes `credit_o == DEPTH`, it returns to idle.
- R8: The credit count goes down by one for each sent flit and up by one for each `credit_i` pulse. A send and a pulse in the same cycle leave it unchanged. It never exceeds `DEPTH`.
- R9: While `credit_o` is 0 no flit is sent, even when the owner has a flit ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_IN | Head flit of input i is waiting for this output |
| flit_vld_i | input | N_IN | Input i has a flit at its buffer front |
| tail_i | input | N_IN | Front flit of input i is a tail flit |
| credit_i | input | 1 | One downstream buffer freed (pulse) |
| send_o | output | 1 | A flit crosses this output this cycle |
| pop_o | output | N_IN | Dequeue strobe per input |
| gnt_o | output | N_IN | One-hot owner while active |
| sel_o | output | IW | Crossbar select: owner index |
| state_o | output | 2 | 0 idle, 1 active, 2 wait |
| credit_o | output | CW | Current credit count |

## Verification
The bench builds the block with three inputs and a downstream depth of three. With three inputs, the round-robin search wraps at a count that is not a power of two. With a depth of three, the count reaches zero within a few sends, so credit starvation, a send and a return in the same cycle, and the full-count exit from wait all happen often. A stretch with no credit returns holds the port at zero credits. A stretch with every input requesting and every flit a tail walks the grant order through several complete rotations.

// File: rtl/wh_port_pkg.sv
package wh_port_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_ACTIVE = 2'd1,
    PS_WAIT   = 2'd2
  } port_state_e;
endpackage

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // search starts one past the last winner
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_i) + k) % N;
      if (!any_o && req_i[c]) begin
        any_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          avail_o,
  output logic          full_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= FULL;
    else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o   = cnt_q;
  assign avail_o = (cnt_q != '0);
  assign full_o  = (cnt_q == FULL);
endmodule

// File: rtl/wh_port_fsm.sv
module wh_port_fsm
  import wh_port_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          any_req_i,
  input  logic [IW-1:0] arb_idx_i,
  input  logic          own_vld_i,
  input  logic          own_tail_i,
  input  logic          credit_avail_i,
  input  logic          credit_full_i,
  output port_state_e   state_o,
  output logic [IW-1:0] owner_o,
  output logic [IW-1:0] last_o,
  output logic          send_o
);
  port_state_e   state_q, state_d;
  logic [IW-1:0] owner_q, last_q;

  assign send_o = (state_q == PS_ACTIVE) && own_vld_i && credit_avail_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:   if (any_req_i) state_d = PS_ACTIVE;
      PS_ACTIVE: if (send_o && own_tail_i) state_d = PS_WAIT;
      PS_WAIT:   if (credit_full_i) state_d = PS_IDLE;
      default:   state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      owner_q <= '0;
      last_q  <= IW'(N - 1);
    end else begin
      state_q <= state_d;
      if (state_q == PS_IDLE && any_req_i) begin
        owner_q <= arb_idx_i;
        last_q  <= arb_idx_i;
      end
    end
  end

  assign state_o = state_q;
  assign owner_o = owner_q;
  assign last_o  = last_q;
endmodule

// File: rtl/wh_out_port.sv
module wh_out_port
  import wh_port_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(N_IN),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] req_i,
  input  logic [N_IN-1:0] flit_vld_i,
  input  logic [N_IN-1:0] tail_i,
  input  logic            credit_i,
  output logic            send_o,
  output logic [N_IN-1:0] pop_o,
  output logic [N_IN-1:0] gnt_o,
  output logic [IW-1:0]   sel_o,
  output logic [1:0]      state_o,
  output logic [CW-1:0]   credit_o
);
  logic          any_req, cr_avail, cr_full, send;
  logic [IW-1:0] arb_idx, owner, last;
  port_state_e   state;

  wh_rr_arb #(.N(N_IN), .IW(IW)) u_arb (
    .req_i (req_i),
    .last_i(last),
    .any_o (any_req),
    .idx_o (arb_idx)
  );

  wh_credit_ctr #(.DEPTH(DEPTH), .CW(CW)) u_cred (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (credit_i),
    .dec_i  (send),
    .cnt_o  (credit_o),
    .avail_o(cr_avail),
    .full_o (cr_full)
  );

  wh_port_fsm #(.N(N_IN), .IW(IW)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .any_req_i     (any_req),
    .arb_idx_i     (arb_idx),
    .own_vld_i     (flit_vld_i[owner]),
    .own_tail_i    (tail_i[owner]),
    .credit_avail_i(cr_avail),
    .credit_full_i (cr_full),
    .state_o       (state),
    .owner_o       (owner),
    .last_o        (last),
    .send_o        (send)
  );

  always_comb begin
    gnt_o = '0;
    if (state == PS_ACTIVE) gnt_o[owner] = 1'b1;
  end

  assign pop_o   = send ? gnt_o : '0;
  assign send_o  = send;
  assign sel_o   = owner;
  assign state_o = state;
endmodule

// File: rtl/wh_out_port_chk.sv
module wh_out_port_chk #(
  parameter int N_IN  = 4,
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  parameter int CW    = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_IN-1:0] tail_i,
  input logic            credit_i,
  input logic            send_o,
  input logic [N_IN-1:0] pop_o,
  input logic [N_IN-1:0] gnt_o,
  input logic [IW-1:0]   sel_o,
  input logic [1:0]      state_o,
  input logic [CW-1:0]   credit_o
);
  assert_credit_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(credit_o) <= DEPTH);

  assert_credit_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> int'(credit_o) == int'($past(credit_o)) + int'($past(credit_i)) - int'($past(send_o)));

  assert_no_send_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_o == '0 |-> !send_o);

  assert_quiet_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd1 |-> (!send_o && pop_o == '0 && gnt_o == '0));

  assert_gnt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 |-> $countones(gnt_o) == 1);

  assert_owner_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !(send_o && tail_i[sel_o])) |=> (state_o == 2'd1 && $stable(gnt_o)));

  assert_tail_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && send_o && tail_i[sel_o]) |=> state_o == 2'd2);

  assert_wait_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && int'(credit_o) == DEPTH) |=> state_o == 2'd0);

  assert_wait_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2 && int'(credit_o) != DEPTH) |=> state_o == 2'd2);
endmodule

bind wh_out_port wh_out_port_chk #(.N_IN(N_IN), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tail_i  (tail_i),
  .credit_i(credit_i),
  .send_o  (send_o),
  .pop_o   (pop_o),
  .gnt_o   (gnt_o),
  .sel_o   (sel_o),
  .state_o (state_o),
  .credit_o(credit_o)
);

// File: tb/wh_out_port_tb.sv
module wh_out_port_tb;
  localparam int N  = 3;
  localparam int D  = 3;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(D + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0, flit_vld_i = '0, tail_i = '0;
  logic          credit_i = 1'b0;
  logic          send_o;
  logic [N-1:0]  pop_o, gnt_o;
  logic [IW-1:0] sel_o;
  logic [1:0]    state_o;
  logic [CW-1:0] credit_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  int m_state = 0, m_credit = D, m_owner = 0, m_last = N - 1;

  always #5 clk_i = ~clk_i;

  wh_out_port #(.N_IN(N), .DEPTH(D)) u_dut (.*);

  function automatic int rr_pick(logic [N-1:0] r, int last);
    for (int k = 1; k <= N; k++) if (r[(last + k) % N]) return (last + k) % N;
    return -1;
  endfunction

  function automatic bit exp_send();
    return (m_state == 1) && flit_vld_i[m_owner] && (m_credit > 0);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    int eg, es;
    es = int'(exp_send());
    eg = (m_state == 1) ? (1 << m_owner) : 0;
    chk(int'(state_o) == m_state, (m_state == 2) ? "R7" : "R2", "state", int'(state_o), m_state);
    chk(int'(credit_o) == m_credit, "R8", "credit", int'(credit_o), m_credit);
    if (m_state != 1)
      chk(send_o == 1'b0 && pop_o == '0, "R3", "send/pop off", int'(pop_o), 0);
    else if (m_credit == 0)
      chk(send_o == 1'b0, "R9", "send at zero credit", int'(send_o), 0);
    else
      chk(int'(send_o) == es, "R4", "send", int'(send_o), es);
    chk(int'(gnt_o) == eg, "R5", "gnt", int'(gnt_o), eg);
    chk(int'(pop_o) == (es ? eg : 0), "R4", "pop", int'(pop_o), es ? eg : 0);
    if (m_state == 1) chk(int'(sel_o) == m_owner, "R4", "sel", int'(sel_o), m_owner);
  endtask

  task automatic model_step();
    bit s;
    s = exp_send();
    case (m_state)
      0: if (req_i != '0) begin m_owner = rr_pick(req_i, m_last); m_last = m_owner; m_state = 1; end
      1: if (s && tail_i[m_owner]) m_state = 2;
      default: if (m_credit == D) m_state = 0;
    endcase
    m_credit = m_credit + int'(credit_i) - int'(s);
  endtask

  // one cycle: drive at negedge, check, model on posedge
  task automatic cycle(int p_req, int p_vld, int p_tail, int p_cr);
    @(negedge clk_i);
    for (int i = 0; i < N; i++) begin
      req_i[i]      = ($urandom % 100) < p_req;
      flit_vld_i[i] = ($urandom % 100) < p_vld;
      tail_i[i]     = ($urandom % 100) < p_tail;
    end
    credit_i = (m_credit < D) && (($urandom % 100) < p_cr);
    #1;
    check_outputs();
    @(posedge clk_i);
    model_step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset values while held
    chk(state_o == 2'd0 && gnt_o == '0 && send_o == 1'b0 && pop_o == '0, "R1", "reset outputs", int'(state_o), 0);
    chk(int'(credit_o) == D, "R1", "reset credit", int'(credit_o), D);
    rst_ni = 1'b1;

    // R2 directed: all request, first winner is 0
    @(negedge clk_i);
    req_i = '1; flit_vld_i = '0; #1;
    check_outputs();
    @(posedge clk_i); model_step();
    @(negedge clk_i); #1;
    chk(int'(sel_o) == 0 && state_o == 2'd1, "R2", "first grant index", int'(sel_o), 0);

    // R2/R6/R7 rotation: all request, every flit a tail
    repeat (300) cycle(100, 80, 100, 60);
    // R8/R9 starvation: no credit returns, flits always ready, no tails
    repeat (40) cycle(100, 100, 0, 0);
    // R5 long packets with mixed credit
    repeat (400) cycle(70, 70, 10, 50);
    // broad random mix
    repeat (4000) cycle(50, 60, 30, 45);
    // R7 drain with slow credit returns
    repeat (400) cycle(60, 90, 50, 10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule